// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands, either both single precision or both double precision. It deposits a 2-bit relation code into one of four condition-code fields of a 64-bit floating-point status word. The caller presents the operands, a precision select, a field select and the current status word, then pulses `start`. One cycle later the block presents the updated status word on `statusOut` and raises `resultValid` for that cycle.

When either operand is a NaN, the comparison is unordered. The invalid-trap enable bit in the incoming status word decides what else happens. If the bit is set, the block raises a one-cycle trap request. If it is clear, the block sets the accrued-invalid flag. In both cases the selected field receives the unordered code.

Top module: `fcmp_cond_unit`

## Requirements
- R1: Equal operands, including positive zero against negative zero, write code 00 into the selected field.
- R2: When operand A is less than operand B, the selected field receives code 01. This also holds when operand A is a negative value against a positive one.
- R3: When operand A is greater than operand B, the selected field receives code 10. Examples are -2.0 against -3.0 and +infinity against a finite value; infinity is not treated as a NaN.
- R4: A NaN is an all-ones exponent with a nonzero fraction. If either operand is a NaN and trap-enable bit 23 of `statusIn` is clear, the field receives 11, accrued-invalid bit 5 is set, and `trapPulse` stays low.
- R5: If either operand is a NaN and bit 23 of `statusIn` is set, the field receives 11 and `trapPulse` is high for exactly one cycle. Bit 5 passes through from `statusIn` unchanged.
- R6: The field select value 0, 1, 2 or 3 places the code at bits [11:10], [33:32], [35:34] or [37:36] respectively. Any earlier contents of the selected field are replaced, whatever they were.
- R7: With `isDouble` = 1, both operands use all 64 bits. With `isDouble` = 0, only bits [31:0] are compared and bits [63:32] are ignored. The result codes are the same in both modes.
- R8: `statusOut`, `trapPulse` and `resultValid` update on the first clock edge after `start` is sampled high. `resultValid` and `trapPulse` are single-cycle pulses.
- R9: All bits of `statusIn` other than the selected field and bit 5 pass to `statusOut` unchanged. While `start` is low, `statusOut` holds its value.
- R10: After reset, `statusOut` is zero and `trapPulse` and `resultValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Compare strobe |
| isDouble | input | 1 | 1: 64-bit operands, 0: 32-bit operands in the low bits |
| fieldSel | input | 2 | Condition-code field to write |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| statusIn | input | 64 | Current status word |
| statusOut | output | 64 | Updated status word |
| trapPulse | output | 1 | Invalid-operation trap request |
| resultValid | output | 1 | statusOut was updated this cycle |

## Verification
The hardest case to reach from the ports is the check that a write truly clears the selected field. The field has to hold 11 before the write, and the new code has to have a zero in a bit that was previously one. To reach it, the stimulus pre-loads each of the four fields with ones in `statusIn` and then compares equal operands, so every field must come back as 00. A second hard case is the zero-magnitude pair with opposite signs, which a plain sign-magnitude compare would order. It is driven in both precisions. So are NaN operands under each setting of the trap-enable bit.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int STATUS_W   = 64;
  localparam int OPND_W     = 64;
  localparam int NUM_FIELDS = 4;
  localparam int SEL_W      = $clog2(NUM_FIELDS);
  localparam int CC_BASE    = 10;  // position of field 0
  localparam int CC_STRIDE  = 2;   // extra spacing between fields 1..3
  localparam int CC_JUMP    = 20;  // distance of field 1 region from base
  localparam int ACCR_INV   = 5;   // accrued-invalid flag
  localparam int TRAP_EN    = 23;  // invalid-trap enable

  typedef enum logic [1:0] {
    CC_EQ  = 2'b00,
    CC_LT  = 2'b01,
    CC_GT  = 2'b10,
    CC_UN  = 2'b11
  } ccode_e;

  typedef struct packed {
    logic capture;
    logic markInvalid;
    logic requestTrap;
  } strobes_t;

  function automatic int fieldPos(input logic [SEL_W-1:0] sel);
    if (sel == '0) return CC_BASE;
    return CC_BASE + CC_JUMP + CC_STRIDE * int'(sel);
  endfunction
endpackage

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   isDouble,
  input  logic [SEL_W-1:0]       fieldSel,
  input  logic [OPND_W-1:0]      opA,
  input  logic [OPND_W-1:0]      opB,
  input  logic [STATUS_W-1:0]    statusIn,
  input  strobes_t               strobes,
  output logic                   unordered,
  output logic [STATUS_W-1:0]    statusOut
);
  localparam int MAG_W = OPND_W - 1;

  logic             signA, signB, nanA, nanB;
  logic [MAG_W-1:0] magA, magB;
  logic             lessRel, greaterRel;
  ccode_e           code;
  logic [STATUS_W-1:0] nextStatus;

  always_comb begin
    if (isDouble) begin
      signA = opA[63];
      signB = opB[63];
      magA  = opA[62:0];
      magB  = opB[62:0];
      nanA  = (&opA[62:52]) && (|opA[51:0]);
      nanB  = (&opB[62:52]) && (|opB[51:0]);
    end else begin
      signA = opA[31];
      signB = opB[31];
      magA  = {{(MAG_W-31){1'b0}}, opA[30:0]};
      magB  = {{(MAG_W-31){1'b0}}, opB[30:0]};
      nanA  = (&opA[30:23]) && (|opA[22:0]);
      nanB  = (&opB[30:23]) && (|opB[22:0]);
    end
  end

  assign unordered = nanA || nanB;

  always_comb begin
    lessRel    = 1'b0;
    greaterRel = 1'b0;
    if (magA == '0 && magB == '0) begin
      lessRel = 1'b0;
    end else if (signA != signB) begin
      lessRel    = signA;
      greaterRel = signB;
    end else if (magA != magB) begin
      lessRel    = (magA < magB) ^ signA;
      greaterRel = !lessRel;
    end
  end

  always_comb begin
    if (unordered)       code = CC_UN;
    else if (lessRel)    code = CC_LT;
    else if (greaterRel) code = CC_GT;
    else                 code = CC_EQ;
  end

  logic [NUM_FIELDS-1:0][STATUS_W-1:0] laneClear;
  logic [NUM_FIELDS-1:0][STATUS_W-1:0] laneSet;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int POS = fieldPos(SEL_W'(g));
    always_comb begin
      laneClear[g] = '0;
      laneSet[g]   = '0;
      if (fieldSel == SEL_W'(g)) begin
        laneClear[g][POS +: 2] = 2'b11;
        laneSet[g][POS +: 2]   = code;
      end
    end
  end

  always_comb begin
    nextStatus = statusIn;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      nextStatus = (nextStatus & ~laneClear[i]) | laneSet[i];
    end
    if (strobes.markInvalid) nextStatus[ACCR_INV] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                statusOut <= '0;
    else if (strobes.capture) statusOut <= nextStatus;
  end
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     unordered,
  input  logic     trapEnable,
  output strobes_t strobes,
  output logic     trapPulse,
  output logic     resultValid
);
  always_comb begin
    strobes.capture     = start;
    strobes.markInvalid = start && unordered && !trapEnable;
    strobes.requestTrap = start && unordered && trapEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapPulse   <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      trapPulse   <= strobes.requestTrap;
      resultValid <= strobes.capture;
    end
  end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
  import fcmp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                isDouble,
  input  logic [1:0]          fieldSel,
  input  logic [63:0]         opA,
  input  logic [63:0]         opB,
  input  logic [63:0]         statusIn,
  output logic [63:0]         statusOut,
  output logic                trapPulse,
  output logic                resultValid
);
  strobes_t strobes;
  logic     unordered;

  fcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .unordered(unordered),
    .trapEnable(statusIn[TRAP_EN]), .strobes(strobes),
    .trapPulse(trapPulse), .resultValid(resultValid)
  );

  fcmp_datapath u_dp (
    .clk(clk), .rstN(rstN), .isDouble(isDouble), .fieldSel(fieldSel),
    .opA(opA), .opB(opB), .statusIn(statusIn), .strobes(strobes),
    .unordered(unordered), .statusOut(statusOut)
  );
endmodule

// File: rtl/fcmp_cond_checker.sv
module fcmp_cond_checker
  import fcmp_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [1:0]  fieldSel,
  input logic [63:0] statusIn,
  input logic [63:0] statusOut,
  input logic        trapPulse,
  input logic        resultValid
);
  function automatic logic [63:0] keepMask();
    logic [63:0] m;
    m = '1;
    for (int i = 0; i < NUM_FIELDS; i++) m[fieldPos(SEL_W'(i)) +: 2] = 2'b00;
    m[ACCR_INV] = 1'b0;
    return m;
  endfunction

  localparam logic [63:0] KEEP = keepMask();

  a_r8_valid_follows_start: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resultValid);
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resultValid);
  a_r5_trap_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> resultValid);
  a_r5_trap_field_unordered: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> statusOut[fieldPos($past(fieldSel)) +: 2] == 2'b11);
  a_r5_trap_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(statusIn[TRAP_EN]));
  a_r9_other_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ((statusOut ^ $past(statusIn)) & KEEP) == '0);
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(statusOut));
endmodule

bind fcmp_cond_unit fcmp_cond_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .fieldSel(fieldSel),
  .statusIn(statusIn), .statusOut(statusOut), .trapPulse(trapPulse),
  .resultValid(resultValid)
);

// File: tb/fcmp_cond_unit_bench.sv
module fcmp_cond_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isDouble = 1'b0;
  logic [1:0]  fieldSel = '0;
  logic [63:0] opA = '0, opB = '0, statusIn = '0;
  logic [63:0] statusOut;
  logic        trapPulse, resultValid;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  fcmp_cond_unit u_fcmp_cond_unit (
    .clk(clk), .rstN(rstN), .start(start), .isDouble(isDouble),
    .fieldSel(fieldSel), .opA(opA), .opB(opB), .statusIn(statusIn),
    .statusOut(statusOut), .trapPulse(trapPulse), .resultValid(resultValid)
  );

  localparam logic [63:0] D_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] D_TWO  = 64'h4000000000000000;
  localparam logic [63:0] D_M2   = 64'hC000000000000000;
  localparam logic [63:0] D_M3   = 64'hC008000000000000;
  localparam logic [63:0] D_NAN  = 64'h7FF8000000000000;
  localparam logic [63:0] D_NZ   = 64'h8000000000000000;
  localparam logic [31:0] S_ONE  = 32'h3F800000;
  localparam logic [31:0] S_TWO  = 32'h40000000;
  localparam logic [31:0] S_NZ   = 32'h80000000;
  localparam logic [31:0] S_INF  = 32'h7F800000;
  localparam logic [31:0] S_NAN  = 32'h7FC00000;

  function automatic int fpos(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 32;
      2'd2: return 34;
      default: return 36;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one compare and checks status, trap and pulse shape.
  task automatic runCmp(input string req, input logic dbl, input logic [1:0] sel,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] sIn, input logic [1:0] code,
                        input logic expTrap, input logic expAccr);
    logic [63:0] exp;
    exp = sIn;
    exp[fpos(sel) +: 2] = code;
    if (expAccr) exp[5] = 1'b1;
    @(negedge clk);
    isDouble = dbl; fieldSel = sel; opA = a; opB = b; statusIn = sIn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " status"}, statusOut, exp);
    check({req, " R8 valid"}, {63'b0, resultValid}, 64'd1);
    check({req, " trap"}, {63'b0, trapPulse}, {63'b0, expTrap});
    @(negedge clk);
    check({req, " R8 pulse end"}, {62'b0, resultValid, trapPulse}, 64'd0);
    check({req, " R9 hold"}, statusOut, exp);
  endtask

  task automatic tReset();
    check("R10 status", statusOut, 64'd0);
    check("R10 flags", {62'b0, trapPulse, resultValid}, 64'd0);
  endtask

  task automatic tEqual();
    runCmp("R1 dbl eq", 1'b1, 2'd0, D_ONE, D_ONE, 64'h0, 2'b00, 1'b0, 1'b0);
    runCmp("R1 sgl zeros", 1'b0, 2'd1, 64'h0, {32'h0, S_NZ}, 64'h0, 2'b00, 1'b0, 1'b0);
    runCmp("R1 dbl zeros", 1'b1, 2'd2, D_NZ, 64'h0, 64'h0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic tLess();
    runCmp("R2 dbl lt", 1'b1, 2'd0, D_ONE, D_TWO, 64'h0, 2'b01, 1'b0, 1'b0);
    runCmp("R2 neg vs pos", 1'b1, 2'd3, D_M3, D_ONE, 64'h0, 2'b01, 1'b0, 1'b0);
    runCmp("R2 sgl lt", 1'b0, 2'd0, {32'h0, S_ONE}, {32'h0, S_TWO}, 64'h0, 2'b01, 1'b0, 1'b0);
  endtask

  task automatic tGreater();
    runCmp("R3 neg gt", 1'b1, 2'd1, D_M2, D_M3, 64'h0, 2'b10, 1'b0, 1'b0);
    runCmp("R3 inf gt", 1'b0, 2'd2, {32'h0, S_INF}, {32'h0, S_ONE}, 64'h0, 2'b10, 1'b0, 1'b0);
  endtask

  task automatic tNanQuiet();
    runCmp("R4 dbl nan", 1'b1, 2'd0, D_NAN, D_ONE, 64'h0, 2'b11, 1'b0, 1'b1);
    runCmp("R4 sgl nan b", 1'b0, 2'd3, {32'h0, S_ONE}, {32'h0, S_NAN}, 64'h0, 2'b11, 1'b0, 1'b1);
  endtask

  task automatic tNanTrap();
    logic [63:0] s;
    s = 64'h0000_0000_0080_0000;  // trap enable bit 23
    runCmp("R5 dbl trap", 1'b1, 2'd1, D_ONE, D_NAN, s, 2'b11, 1'b1, 1'b0);
    runCmp("R5 sgl trap", 1'b0, 2'd0, {32'h0, S_NAN}, {32'h0, S_NAN}, s, 2'b11, 1'b1, 1'b0);
  endtask

  task automatic tFields();
    logic [63:0] s;
    s = 64'hA5A5_A53F_5A5A_0C5A;  // all four fields preloaded with 11, bit 23 clear
    for (int f = 0; f < 4; f++)
      runCmp("R6 field clear", 1'b1, 2'(f), D_TWO, D_TWO, s, 2'b00, 1'b0, 1'b0);
    runCmp("R6 field3 gt", 1'b1, 2'd3, D_TWO, D_ONE, s, 2'b10, 1'b0, 1'b0);
  endtask

  task automatic tSingleUpper();
    runCmp("R7 upper ignored", 1'b0, 2'd2, {32'hFFFF_FFFF, S_ONE}, {32'h0, S_ONE},
           64'h0, 2'b00, 1'b0, 1'b0);
    runCmp("R7 upper nan ignored", 1'b0, 2'd1, {32'h7FF8_0000, S_TWO}, {32'h0, S_ONE},
           64'h0, 2'b10, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tEqual();
    tLess();
    tGreater();
    tNanQuiet();
    tNanTrap();
    tFields();
    tSingleUpper();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule